// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block holds a Hamming encoder and a Hamming decoder side by side, each with one register stage. The encoder takes a data word of `DATA_W` bits and returns a codeword one cycle later. In that codeword, check bits sit at the one-based positions that are powers of two. The data bits fill the remaining positions in ascending order, with data bit 0 at the lowest free position.

The decoder takes a received codeword and recomputes every check group to form a syndrome. It treats a nonzero syndrome as the one-based position of a single flipped bit, inverts that bit and returns the repaired data word. It also returns a corrected flag and the position it repaired.

A syndrome that points past the end of the codeword cannot come from a single error. In that case the decoder raises an uncorrectable flag and passes the data bits through as received. The parameter `ODD_PARITY` sets the parity sense. Both halves of one instance use the same sense, so a link needs matching parameters at both ends.

Top module: `hamming_sec_codec`

## Requirements
- R1: The number of check bits is the smallest k with 2^k >= DATA_W + k + 1, and the codeword is DATA_W + k bits wide: 7 bits for DATA_W=4 and 9 bits for DATA_W=5.
- R2: Codeword bit p-1 holds position p. Positions 1, 2, 4, 8 and so on carry check bits. Data bit i goes to the (i+1)-th position that is not a power of two, counted upward; for DATA_W=4, data bits 0 to 3 sit at positions 3, 5, 6 and 7.
- R3: Check bit j covers every position whose index has bit j set. With ODD_PARITY=0, each covered group including its check bit has an even number of ones.
- R4: With ODD_PARITY=1, each covered group including its check bit has an odd number of ones, and the decoder of that instance expects the same sense.
- R5: A codeword with no error decodes to the original data, with the corrected flag low, the uncorrectable flag low and a reported position of 0.
- R6: A codeword with exactly one flipped bit at position p decodes to the original data, with the corrected flag high and a reported position of p.
- R7: When the syndrome exceeds the codeword length, the uncorrectable flag goes high, the corrected flag stays low, the position reads 0 and the data bits are returned unrepaired.
- R8: Each output valid follows its input valid with one cycle of latency. While an input valid is low, that side's data outputs hold their last values.
- R9: During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enc_valid_i | input | 1 | Encoder input strobe |
| enc_data_i | input | DATA_W | Data word to encode |
| enc_valid_o | output | 1 | Encoder output strobe |
| enc_code_o | output | CODE_W | Encoded codeword |
| dec_valid_i | input | 1 | Decoder input strobe |
| dec_code_i | input | CODE_W | Received codeword |
| dec_valid_o | output | 1 | Decoder output strobe |
| dec_data_o | output | DATA_W | Repaired data word |
| dec_fixed_o | output | 1 | A single bit was inverted |
| dec_bad_o | output | 1 | Syndrome beyond codeword length |
| dec_pos_o | output | CHK_W | One-based position that was inverted, else 0 |

## Verification
The assertions assume that every input is a known 0 or 1 whenever its valid is high. They also assume that `DATA_W` lies within the range the check-bit count expression covers; the stimulus uses default and small widths only. Decoder codewords always start from a correctly encoded word. The stimulus then flips zero, one or two chosen bits, so each syndrome the flags report on is one the bench can predict as the XOR of the flipped positions. A second instance, 5 bits wide with odd parity, is the one that reaches syndromes beyond the codeword length.

// File: rtl/hamming_sec_codec.sv
module hamming_sec_codec #(
  parameter int DATA_W = 4,
  parameter bit ODD_PARITY = 1'b0,
  localparam int CHK_W = (DATA_W <= 1) ? 2 : (DATA_W <= 4) ? 3 : (DATA_W <= 11) ? 4 :
                         (DATA_W <= 26) ? 5 : (DATA_W <= 57) ? 6 : (DATA_W <= 120) ? 7 : 8,
  localparam int CODE_W = DATA_W + CHK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_valid_i,
  input  logic [DATA_W-1:0] enc_data_i,
  output logic              enc_valid_o,
  output logic [CODE_W-1:0] enc_code_o,
  input  logic              dec_valid_i,
  input  logic [CODE_W-1:0] dec_code_i,
  output logic              dec_valid_o,
  output logic [DATA_W-1:0] dec_data_o,
  output logic              dec_fixed_o,
  output logic              dec_bad_o,
  output logic [CHK_W-1:0]  dec_pos_o
);

  function automatic bit is_pow2(input int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic logic [CODE_W-1:0] scatter(input logic [DATA_W-1:0] d);
    logic [CODE_W-1:0] c;
    int di;
    c = '0;
    di = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_pow2(p)) begin
        c[p-1] = d[di];
        di++;
      end
    end
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] gather(input logic [CODE_W-1:0] c);
    logic [DATA_W-1:0] d;
    int di;
    d = '0;
    di = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_pow2(p)) begin
        d[di] = c[p-1];
        di++;
      end
    end
    return d;
  endfunction

  function automatic logic [CHK_W-1:0] syndrome(input logic [CODE_W-1:0] c);
    logic [CHK_W-1:0] s;
    for (int j = 0; j < CHK_W; j++) begin
      s[j] = ODD_PARITY;
      for (int p = 1; p <= CODE_W; p++)
        if (((p >> j) & 1) == 1) s[j] = s[j] ^ c[p-1];
    end
    return s;
  endfunction

  logic [CODE_W-1:0] enc_word;
  logic [CHK_W-1:0]  enc_chk;
  logic [CODE_W-1:0] enc_next;

  assign enc_word = scatter(enc_data_i);
  assign enc_chk  = syndrome(enc_word);

  always_comb begin
    enc_next = enc_word;
    for (int j = 0; j < CHK_W; j++)
      if ((1 << j) <= CODE_W) enc_next[(1 << j) - 1] = enc_chk[j];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enc_valid_o <= 1'b0;
      enc_code_o  <= '0;
    end else begin
      enc_valid_o <= enc_valid_i;
      if (enc_valid_i) enc_code_o <= enc_next;
    end
  end

  logic [CHK_W-1:0]  syn;
  logic              fix, bad;
  logic [CODE_W-1:0] flip;

  assign syn = syndrome(dec_code_i);
  assign bad = int'(syn) > CODE_W;
  assign fix = (syn != '0) && !bad;

  always_comb begin
    for (int p = 1; p <= CODE_W; p++)
      flip[p-1] = fix && (int'(syn) == p);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_o <= 1'b0;
      dec_data_o  <= '0;
      dec_fixed_o <= 1'b0;
      dec_bad_o   <= 1'b0;
      dec_pos_o   <= '0;
    end else begin
      dec_valid_o <= dec_valid_i;
      if (dec_valid_i) begin
        dec_data_o  <= gather(dec_code_i ^ flip);
        dec_fixed_o <= fix;
        dec_bad_o   <= bad;
        dec_pos_o   <= fix ? syn : '0;
      end
    end
  end

  assert_enc_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enc_valid_o |-> syndrome(enc_code_o) == '0);

  assert_flags_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dec_fixed_o && dec_bad_o));

  assert_pos_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fixed_o |-> (dec_pos_o != '0) && (int'(dec_pos_o) <= CODE_W));

  assert_pos_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_fixed_o |-> dec_pos_o == '0);

  assert_dec_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid_i |=> $stable(dec_data_o) && $stable(dec_fixed_o) && $stable(dec_bad_o));

  assert_enc_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enc_valid_i |=> $stable(enc_code_o));

endmodule

// File: tb/hamming_sec_codec_test.sv
module hamming_sec_codec_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errs = 0;
  bit finished = 1'b0;

  logic       ev4 = 0, dv4 = 0, evo4, dvo4, fx4, bd4;
  logic [3:0] ed4 = 0, dd4;
  logic [6:0] ec4, dc4 = 0;
  logic [2:0] ps4;

  logic       ev5 = 0, dv5 = 0, evo5, dvo5, fx5, bd5;
  logic [4:0] ed5 = 0, dd5;
  logic [8:0] ec5, dc5 = 0;
  logic [3:0] ps5;

  hamming_sec_codec uut (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_i(ev4), .enc_data_i(ed4), .enc_valid_o(evo4), .enc_code_o(ec4),
    .dec_valid_i(dv4), .dec_code_i(dc4), .dec_valid_o(dvo4), .dec_data_o(dd4),
    .dec_fixed_o(fx4), .dec_bad_o(bd4), .dec_pos_o(ps4));

  hamming_sec_codec #(.DATA_W(5), .ODD_PARITY(1'b1)) uut_odd (
    .clk(clk), .rst_n(rst_n),
    .enc_valid_i(ev5), .enc_data_i(ed5), .enc_valid_o(evo5), .enc_code_o(ec5),
    .dec_valid_i(dv5), .dec_code_i(dc5), .dec_valid_o(dvo5), .dec_data_o(dd5),
    .dec_fixed_o(fx5), .dec_bad_o(bd5), .dec_pos_o(ps5));

  function automatic int kof(input int n);
    int k = 1;
    while ((1 << k) < n + k + 1) k++;
    return k;
  endfunction

  function automatic logic [15:0] model_enc(input logic [15:0] d, input int n, input bit odd);
    logic [15:0] c = '0;
    int k = kof(n);
    int di = 0;
    for (int p = 1; p <= n + k; p++)
      if ((p & (p - 1)) != 0) begin c[p-1] = d[di]; di++; end
    for (int j = 0; j < k; j++) begin
      logic par = odd;
      for (int p = 1; p <= n + k; p++)
        if (((p >> j) & 1) == 1 && p != (1 << j)) par ^= c[p-1];
      c[(1 << j) - 1] = par;
    end
    return c;
  endfunction

  function automatic logic [15:0] model_ext(input logic [15:0] c, input int n);
    logic [15:0] d = '0;
    int di = 0;
    for (int p = 1; di < n; p++)
      if ((p & (p - 1)) != 0) begin d[di] = c[p-1]; di++; end
    return d;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run4_dec(input logic [6:0] code, input int p, input logic [3:0] d);
    @(negedge clk);
    dv4 = 1; dc4 = (p == 0) ? code : code ^ (7'd1 << (p - 1));
    @(negedge clk);
    dv4 = 0;
    if (p == 0) begin
      chk("R5", "data", dd4, d); chk("R5", "fixed", fx4, 0);
      chk("R5", "bad", bd4, 0);  chk("R5", "pos", ps4, 0);
    end else begin
      chk("R6", "data", dd4, d); chk("R6", "fixed", fx4, 1); chk("R6", "pos", ps4, p);
    end
    chk("R8", "dec valid", dvo4, 1);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk("R9", "enc valid", evo4, 0); chk("R9", "enc code", ec4, 0);
    chk("R9", "dec valid", dvo4, 0); chk("R9", "dec data", dd4, 0);
    chk("R9", "flags", {fx4, bd4}, 0); chk("R9", "pos", ps4, 0);
    rst_n = 1;
    chk("R1", "code width n4", $bits(ec4), 7);
    chk("R1", "code width n5", $bits(ec5), 9);

    for (int d = 0; d < 16; d++) begin
      logic [6:0] exp_code;
      exp_code = model_enc(16'(d), 4, 1'b0);
      @(negedge clk); ev4 = 1; ed4 = 4'(d);
      @(negedge clk); ev4 = 0;
      chk("R8", "enc valid", evo4, 1);
      chk("R3", "even code", ec4, exp_code);
      chk("R2", "data placement", {ec4[6], ec4[5], ec4[4], ec4[2]}, d);
      for (int p = 0; p <= 7; p++) run4_dec(ec4, p, 4'(d));
    end

    @(negedge clk); ev4 = 0; dv4 = 0; ed4 = 4'hA; dc4 = 7'h7F;
    @(negedge clk);
    chk("R8", "enc valid low", evo4, 0);
    chk("R8", "enc hold", ec4, model_enc(16'hF, 4, 1'b0));
    chk("R8", "dec valid low", dvo4, 0);
    chk("R8", "dec hold", dd4, 15);

    for (int it = 0; it < 300; it++) begin
      logic [4:0] d;
      logic [8:0] code;
      int a, b, s;
      d = 5'($urandom);
      if (it == 0) d = 5'h00;
      if (it == 1) d = 5'h1F;
      @(negedge clk); ev5 = 1; ed5 = d;
      @(negedge clk); ev5 = 0;
      code = ec5;
      chk("R4", "odd code", code, model_enc(16'(d), 5, 1'b1));
      a = int'($urandom_range(9, 0));
      b = int'($urandom_range(9, 1));
      if (it == 2) begin a = 8; b = 7; end
      if (a == b) b = 0;
      if (a != 0) code[a-1] = ~code[a-1];
      if (b != 0) code[b-1] = ~code[b-1];
      s = a ^ b;
      @(negedge clk); dv5 = 1; dc5 = code;
      @(negedge clk); dv5 = 0;
      if (s > 9) begin
        chk("R7", "bad", bd5, 1); chk("R7", "fixed", fx5, 0);
        chk("R7", "pos", ps5, 0);
        chk("R7", "passthrough", dd5, model_ext(16'(code), 5));
      end else if (s == 0) begin
        chk("R5", "odd clean data", dd5, d); chk("R5", "odd clean flags", {fx5, bd5}, 0);
      end else begin
        logic [8:0] rep;
        rep = code; rep[s-1] = ~rep[s-1];
        chk("R6", "odd fixed", fx5, 1); chk("R6", "odd pos", ps5, s);
        chk("R6", "odd data", dd5, model_ext(16'(rep), 5));
        if (a == 0 || b == 0) chk("R4", "odd single repair", dd5, d);
      end
    end

    if (!finished) begin
      finished = 1;
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++; n_errs++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("  Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
    end
  end
endmodule